// File: doc/BRIEF.md
# Dual Transmit Buffer Controller

This block sits between a processor and a byte-wide transmit stream. It holds either one or two packet buffers. Each buffer has its own length register and its own status register, and all of them sit on a simple word-addressed register bus. Software fills a buffer with frame words and writes the frame length. It then sets the buffer's busy bit, which hands the buffer to the hardware. The controller serialises the frame onto a valid/ready byte stream and clears busy once the last byte has been accepted. Software can therefore fill one buffer while the other is being sent.

A status write that sets the busy bit and the program bit together does not send a frame. Instead, the controller copies the first six bytes of that buffer into the station address output. A status write with the busy bit clear cancels whatever the buffer was doing. Each buffer has an interrupt-enable bit that makes the controller give a one-cycle pulse whenever the hardware finishes with that buffer.

Top module: `tpp_tx_ctrl`

## Requirements
- R1: The bus address is a 10-bit word address. Bit 9 selects the buffer (0 first, 1 second). Within a buffer, word offsets below the buffer depth are frame data, offset 0x1FD is the length register (bits 15:0), and offset 0x1FF is status. In status, bit 0 is busy, bit 1 is program and bit 3 is interrupt enable. All of these read back on `bus_rdata`.
- R2: A status write with bit 0 set and bit 1 clear, made to an idle buffer, starts a transmission. Status bit 0 reads 1 until the last byte has been accepted and reads 0 afterwards. Bit 3 keeps the value written.
- R3: A frame of N bytes sends exactly N bytes. Bytes are taken from each data word starting with bits 7:0. `tx_last` is asserted with byte N only, and pad bytes in the last word are never sent. A length of 0 sends nothing and still clears busy.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: When both buffers are waiting, frames leave in the order in which their busy bits were set. No buffer is skipped.
- R6: A status write with bits 0 and 1 both set loads `mac_addr` from bytes 0 to 5 of the buffer, with byte 0 in `mac_addr[47:40]`. No stream byte is sent, and bits 0 and 1 read 0 once the load has finished.
- R7: A status write with bit 0 clear cancels that buffer's transmission or program job. Busy and program read 0 from the next cycle, `tx_valid` drops, no further byte of that frame is sent, and no interrupt is raised.
- R8: `tx_irq` pulses high for exactly one cycle when the hardware completes a buffer whose interrupt enable is set. It stays low when that enable is clear.
- R9: With `TWO_BUF` = 0, the second buffer does not exist. Writes to its addresses are ignored and its addresses read 0.
- R10: After reset, `tx_valid`, `tx_irq` and `mac_addr` are 0, and every status and length register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_irq | output | 1 | Completion interrupt pulse |
| mac_addr | output | 48 | Station address |

## Verification
The stall-hold property assumes that the only thing which may withdraw a stalled byte is a cancelling status write. For this reason the bench cancels a frame only while the sink is held not-ready, and it checks separately that the stream falls silent afterwards. The checkers also assume that software never sets busy on a buffer that is already busy, and never rewrites a buffer's length or data while the hardware owns it. The bench only starts a buffer after polling its status back to idle, or when that buffer is known to be free. Frame lengths stay within the buffer depth, so byte indices never wrap.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    localparam int ADDR_W = 10;
    localparam int OFF_W  = 9;

    localparam logic [OFF_W-1:0] LEN_OFF  = 9'h1FD;
    localparam logic [OFF_W-1:0] STAT_OFF = 9'h1FF;

    localparam int BUSY_BIT = 0;
    localparam int PROG_BIT = 1;
    localparam int IE_BIT   = 3;

    localparam int MAC_BYTES = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_PROG = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic        busy;
        logic        prog;
        logic        ie;
        logic [15:0] len;
    } buf_state_t;

endpackage

// File: rtl/tpp_buf_regs.sv
module tpp_buf_regs
    import tpp_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [BUF_AW-1:0] eng_idx,
    output logic [31:0]       eng_word,
    input  logic              done,
    output logic              busy,
    output logic              prog,
    output logic              ie,
    output logic [15:0]       len,
    output logic              set_pulse,
    output logic              abort_pulse
);
    localparam int DEPTH = 1 << BUF_AW;
    localparam logic [OFF_W-1:0] DEPTH_OFF = OFF_W'(DEPTH);

    buf_state_t  st_d, st_q;
    logic [31:0] mem [DEPTH];
    logic        data_hit;

    assign data_hit = (off < DEPTH_OFF);

    always_comb begin
        st_d        = st_q;
        set_pulse   = 1'b0;
        abort_pulse = 1'b0;
        if (done) begin
            st_d.busy = 1'b0;
            st_d.prog = 1'b0;
        end
        if (wr_en && off == LEN_OFF) begin
            st_d.len = wdata[15:0];
        end
        if (wr_en && off == STAT_OFF) begin
            st_d.ie = wdata[IE_BIT];
            if (wdata[BUSY_BIT]) begin
                if (!st_q.busy) begin
                    st_d.busy = 1'b1;
                    st_d.prog = wdata[PROG_BIT];
                    set_pulse = 1'b1;
                end
            end else begin
                st_d.busy   = 1'b0;
                st_d.prog   = 1'b0;
                abort_pulse = st_q.busy;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && data_hit) mem[off[BUF_AW-1:0]] <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (off == LEN_OFF)       rdata = {16'b0, st_q.len};
        else if (off == STAT_OFF) rdata = {28'b0, st_q.ie, 1'b0, st_q.prog, st_q.busy};
        else if (data_hit)        rdata = mem[off[BUF_AW-1:0]];
    end

    assign eng_word = mem[eng_idx];
    assign busy     = st_q.busy;
    assign prog     = st_q.prog;
    assign ie       = st_q.ie;
    assign len      = st_q.len;

    assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == STAT_OFF && !wdata[BUSY_BIT]) |=> (!busy && !prog));

    assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> busy);

    assert_done_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: rtl/tpp_tx_engine.sv
module tpp_tx_engine
    import tpp_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        busy,
    input  logic [1:0]        prog,
    input  logic [1:0]        ie,
    input  logic [1:0]        set_p,
    input  logic [1:0]        abort_p,
    input  logic [15:0]       len0,
    input  logic [15:0]       len1,
    input  logic [31:0]       word0,
    input  logic [31:0]       word1,
    output logic [BUF_AW-1:0] idx,
    output logic [1:0]        done,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_irq,
    output logic [47:0]       mac_addr
);
    typedef struct packed {
        eng_state_e  state;
        logic        cur;
        logic        older;
        logic [15:0] cnt;
        logic [15:0] len;
        logic [47:0] stage;
        logic [47:0] mac;
        logic        irq;
    } eng_t;

    eng_t        e_d, e_q;
    logic [1:0]  avail;
    logic        pick;
    logic [31:0] word;
    logic [7:0]  cur_byte;
    logic        is_last;

    assign avail    = busy & ~abort_p;
    assign pick     = (avail == 2'b11) ? e_q.older : avail[1];
    assign word     = e_q.cur ? word1 : word0;
    assign cur_byte = word[{e_q.cnt[1:0], 3'b000} +: 8];
    assign is_last  = (e_q.cnt == e_q.len - 16'd1);
    assign idx      = e_q.cnt[BUF_AW+1:2];

    always_comb begin
        e_d     = e_q;
        e_d.irq = 1'b0;
        done    = 2'b00;
        if (set_p[0] && !busy[1])      e_d.older = 1'b0;
        else if (set_p[1] && !busy[0]) e_d.older = 1'b1;
        case (e_q.state)
            ST_IDLE: begin
                if (|avail) begin
                    e_d.cur   = pick;
                    e_d.cnt   = '0;
                    e_d.len   = pick ? len1 : len0;
                    e_d.state = prog[pick] ? ST_PROG : ST_SEND;
                end
            end
            ST_SEND: begin
                if (abort_p[e_q.cur]) begin
                    e_d.state = ST_IDLE;
                end else if (e_q.len == '0 || (tx_ready && is_last)) begin
                    done[e_q.cur] = 1'b1;
                    e_d.irq       = ie[e_q.cur];
                    e_d.state     = ST_IDLE;
                end else if (tx_ready) begin
                    e_d.cnt = e_q.cnt + 16'd1;
                end
            end
            ST_PROG: begin
                if (abort_p[e_q.cur]) begin
                    e_d.state = ST_IDLE;
                end else begin
                    e_d.stage = {e_q.stage[39:0], cur_byte};
                    e_d.cnt   = e_q.cnt + 16'd1;
                    if (e_q.cnt == 16'(MAC_BYTES - 1)) begin
                        e_d.mac       = {e_q.stage[39:0], cur_byte};
                        done[e_q.cur] = 1'b1;
                        e_d.irq       = ie[e_q.cur];
                        e_d.state     = ST_IDLE;
                    end
                end
            end
            default: e_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{state: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign tx_valid = (e_q.state == ST_SEND) && (e_q.len != '0);
    assign tx_last  = tx_valid && is_last;
    assign tx_data  = tx_valid ? cur_byte : 8'h00;
    assign tx_irq   = e_q.irq;
    assign mac_addr = e_q.mac;

    assert_owner_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state != ST_IDLE) |-> busy[e_q.cur]);

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !abort_p[e_q.cur]) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    assert_one_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    assert_mac_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state != ST_PROG) |=> $stable(mac_addr));

endmodule

// File: rtl/tpp_tx_ctrl.sv
module tpp_tx_ctrl
    import tpp_pkg::*;
#(
    parameter bit TWO_BUF = 1'b1,
    parameter int BUF_AW  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [9:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        tx_irq,
    output logic [47:0] mac_addr
);
    localparam int NBUF = TWO_BUF ? 2 : 1;

    logic [1:0]        busy, prog, ie, set_p, abort_p, done;
    logic [15:0]       len_a [2];
    logic [31:0]       rd_a  [2];
    logic [31:0]       eng_w [2];
    logic [BUF_AW-1:0] eng_idx;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        if (b < NBUF) begin : g_on
            tpp_buf_regs #(.BUF_AW(BUF_AW)) buf_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (bus_we && (bus_addr[ADDR_W-1] == 1'(b))),
                .off         (bus_addr[OFF_W-1:0]),
                .wdata       (bus_wdata),
                .rdata       (rd_a[b]),
                .eng_idx     (eng_idx),
                .eng_word    (eng_w[b]),
                .done        (done[b]),
                .busy        (busy[b]),
                .prog        (prog[b]),
                .ie          (ie[b]),
                .len         (len_a[b]),
                .set_pulse   (set_p[b]),
                .abort_pulse (abort_p[b])
            );
        end else begin : g_off
            assign rd_a[b]    = '0;
            assign eng_w[b]   = '0;
            assign busy[b]    = 1'b0;
            assign prog[b]    = 1'b0;
            assign ie[b]      = 1'b0;
            assign len_a[b]   = '0;
            assign set_p[b]   = 1'b0;
            assign abort_p[b] = 1'b0;
        end
    end

    assign bus_rdata = rd_a[bus_addr[ADDR_W-1]];

    tpp_tx_engine #(.BUF_AW(BUF_AW)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .prog     (prog),
        .ie       (ie),
        .set_p    (set_p),
        .abort_p  (abort_p),
        .len0     (len_a[0]),
        .len1     (len_a[1]),
        .word0    (eng_w[0]),
        .word1    (eng_w[1]),
        .idx      (eng_idx),
        .done     (done),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .tx_irq   (tx_irq),
        .mac_addr (mac_addr)
    );

    assert_absent_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!TWO_BUF && bus_addr[ADDR_W-1]) |-> (bus_rdata == '0));

endmodule

// File: tb/tpp_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module tpp_tx_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_last, tx_irq, tx_ready;
    logic [7:0]  tx_data;
    logic [47:0] mac_addr;

    logic        s_we = 1'b0;
    logic [9:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_valid, s_last, s_irq;
    logic [7:0]  s_data;
    logic [47:0] s_mac;

    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;

    tpp_tx_ctrl #(.TWO_BUF(1'b1), .BUF_AW(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_irq(tx_irq), .mac_addr(mac_addr));

    tpp_tx_ctrl #(.TWO_BUF(1'b0), .BUF_AW(6)) dut_single_i (
        .clk(clk), .rst_n(rst_n), .bus_we(s_we), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .tx_valid(s_valid),
        .tx_data(s_data), .tx_last(s_last), .tx_ready(1'b1),
        .tx_irq(s_irq), .mac_addr(s_mac));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    logic [7:0] exp_byte [4096];
    bit         exp_last [4096];
    int         exp_wr = 0;
    int         mon_rd = 0;
    int         irq_cnt = 0;
    bit         prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    bit         prev_last = 1'b0;

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (tx_irq) irq_cnt++;
            if (prev_stall && tx_valid)
                check(tx_data == prev_data && tx_last == prev_last, "R4 stall hold",
                      {tx_last, tx_data}, {prev_last, prev_data});
            if (tx_valid && tx_ready) begin
                if (mon_rd >= exp_wr) begin
                    check(1'b0, "R3 unexpected byte", tx_data, 0);
                end else begin
                    check(tx_data == exp_byte[mon_rd] && tx_last == exp_last[mon_rd],
                          "R3 R5 stream byte", {tx_last, tx_data},
                          {exp_last[mon_rd], exp_byte[mon_rd]});
                    mon_rd++;
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 3);
    endfunction

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    function automatic logic [9:0] ad(input int b, input int off);
        return 10'((b << 9) | off);
    endfunction

    task automatic load_frame(input int b, input int len, input int seed);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++)
                word[k*8 +: 8] = (w*4 + k < len) ? pat(seed, w*4 + k) : 8'hA5;
            wr(ad(b, w), word);
        end
    endtask

    task automatic start(input int b, input int len, input int seed, input bit ie, input bit push);
        wr(ad(b, 9'h1FD), 32'(len));
        if (push)
            for (int i = 0; i < len; i++) begin
                exp_byte[exp_wr] = pat(seed, i);
                exp_last[exp_wr] = (i == len - 1);
                exp_wr++;
            end
        wr(ad(b, 9'h1FF), {28'b0, ie, 3'b001});
    endtask

    task automatic wait_idle();
        logic [31:0] s0, s1;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            rd(ad(0, 9'h1FF), s0);
            rd(ad(1, 9'h1FF), s1);
            if (!s0[0] && !s1[0]) return;
        end
        check(1'b0, "R2 busy never cleared", 1, 0);
    endtask

    initial begin
        repeat (3000000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(!tx_valid && !tx_irq && mac_addr == 0, "R10 reset outputs", {tx_valid, tx_irq}, 0);
        rd(ad(0, 9'h1FF), v); check(v == 0, "R10 ping status", v, 0);
        rd(ad(1, 9'h1FD), v); check(v == 0, "R10 pong length", v, 0);

        // R1 data and length readback
        wr(ad(1, 3), 32'hCAFE_F00D);
        rd(ad(1, 3), v); check(v == 32'hCAFE_F00D, "R1 data readback", v, 32'hCAFE_F00D);
        wr(ad(0, 9'h1FD), 32'hFFFF_1234);
        rd(ad(0, 9'h1FD), v); check(v == 32'h1234, "R1 length field", v, 32'h1234);

        // R2 R3 R8 sweep over lengths, both buffers, ready patterns
        for (int b = 0; b < 2; b++)
            for (int len = 0; len <= 13; len++) begin
                bit ie = len[0];
                rdy_mode = (len % 3 == 0) ? 1 : 0;
                load_frame(b, len, len + 16 * b);
                irq0 = irq_cnt;
                start(b, len, len + 16 * b, ie, 1'b1);
                rd(ad(b, 9'h1FF), v);
                check(v[0] == 1'b1, "R2 busy after start", v, 1);
                wait_idle();
                repeat (2) @(negedge clk);
                rd(ad(b, 9'h1FF), v);
                check(v == {28'b0, ie, 3'b000}, "R2 status after done", v, {ie, 3'b000});
                check(mon_rd == exp_wr, "R3 byte count", mon_rd, exp_wr);
                check(irq_cnt - irq0 == int'(ie), "R8 irq count", irq_cnt - irq0, ie);
            end

        // R3 long frames with random back-pressure
        rdy_mode = 1;
        load_frame(0, 255, 91);
        start(0, 255, 91, 1'b1, 1'b1);
        wait_idle();
        load_frame(1, 64, 92);
        start(1, 64, 92, 1'b0, 1'b1);
        wait_idle();
        @(negedge clk);
        check(mon_rd == exp_wr, "R3 long frames count", mon_rd, exp_wr);

        // R5 order: second buffer first, then first, with sink stalled
        rdy_mode = 2;
        load_frame(0, 5, 50);
        load_frame(1, 6, 60);
        irq0 = irq_cnt;
        start(1, 6, 60, 1'b1, 1'b1);
        start(0, 5, 50, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rdy_mode = 0;
        wait_idle();
        @(negedge clk);
        check(mon_rd == exp_wr, "R5 both frames sent", mon_rd, exp_wr);
        check(irq_cnt - irq0 == 2, "R8 two completions", irq_cnt - irq0, 2);

        // R6 station address load from each buffer
        wr(ad(0, 0), 32'h4433_2211);
        wr(ad(0, 1), 32'hBBAA_6655);
        irq0 = irq_cnt;
        wr(ad(0, 9'h1FF), 32'hB);
        wait_idle();
        @(negedge clk);
        rd(ad(0, 9'h1FF), v);
        check(v == 32'h8, "R6 status after load", v, 8);
        check(mac_addr == 48'h1122_3344_5566, "R6 mac from first buffer", mac_addr, 48'h1122_3344_5566);
        check(irq_cnt - irq0 == 1, "R8 irq after load", irq_cnt - irq0, 1);
        check(mon_rd == exp_wr, "R6 no stream bytes", mon_rd, exp_wr);
        wr(ad(1, 0), 32'hD4C3_B2A1);
        wr(ad(1, 1), 32'h0000_F6E5);
        wr(ad(1, 9'h1FF), 32'h3);
        wait_idle();
        @(negedge clk);
        check(mac_addr == 48'hA1B2_C3D4_E5F6, "R6 mac from second buffer", mac_addr, 48'hA1B2_C3D4_E5F6);

        // R7 cancel while stalled mid-frame
        rdy_mode = 2;
        load_frame(0, 20, 77);
        irq0 = irq_cnt;
        start(0, 20, 77, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b1, "R7 frame pending before cancel", tx_valid, 1);
        wr(ad(0, 9'h1FF), 32'h0);
        #1;
        check(tx_valid == 1'b0, "R7 valid drops", tx_valid, 0);
        rd(ad(0, 9'h1FF), v);
        check(v == 0, "R7 status cleared", v, 0);
        rdy_mode = 0;
        repeat (10) @(negedge clk);
        #1;
        check(!tx_valid && mon_rd == exp_wr, "R7 stream silent", mon_rd, exp_wr);
        check(irq_cnt == irq0, "R7 no irq", irq_cnt - irq0, 0);

        // R9 single-buffer configuration
        @(negedge clk);
        s_we = 1'b1; s_addr = 10'h3FD; s_wdata = 32'd4;
        @(negedge clk);
        s_addr = 10'h3FF; s_wdata = 32'h1;
        @(negedge clk);
        s_we = 1'b0;
        #0.5;
        check(s_rdata == 0, "R9 absent status reads 0", s_rdata, 0);
        s_addr = 10'h3FD;
        #0.5;
        check(s_rdata == 0, "R9 absent length reads 0", s_rdata, 0);
        repeat (5) @(negedge clk);
        check(!s_valid && !s_irq, "R9 nothing sent", s_valid, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule